// File: doc/BRIEF.md
# Table-Driven Panel Bring-Up Sequencer

This block powers up a display controller that sits on an 8-bit parallel write bus of the 8080 kind. A pulse on `start` makes it drive a timed hardware reset to the panel. It then walks a small constant table of 16-bit word pairs and plays each pair out. A pair is either a register write, made of a register index and a 16-bit value, or a timing command. The timing command is marked by a reserved index word. With a nonzero second word it waits that many milliseconds. With a zero second word it ends the walk. Once the end entry is reached, `done` rises and stays high until the next `start`.

Every 16-bit word goes out as two bytes, high byte first. Each byte is latched by one low-then-high pulse on `panel_wr_n`. The register index is sent with `panel_dc` low and the value with `panel_dc` high. All waits are whole milliseconds. The millisecond tick comes from a prescaler of `CLK_HZ/1000` clock cycles, written T below.

The controller has these states:
- `ST_IDLE` moves to `ST_RST_LOW` on `start`.
- `ST_RST_LOW` moves to `ST_RST_WAIT` when its timer expires.
- `ST_RST_WAIT` moves to `ST_FETCH` when its timer expires.
- `ST_FETCH` decodes the current pair. A register pair leads to `ST_IDX`, a wait pair to `ST_WAIT`, and the end pair to `ST_DONE`.
- `ST_IDX` moves to `ST_DAT` when the index word has been sent.
- `ST_DAT` moves to `ST_FETCH` with the pointer advanced by 2 words when the value word has been sent.
- `ST_WAIT` moves to `ST_FETCH` with the pointer advanced by 2 words when its timer expires.
- `ST_DONE` moves to `ST_RST_LOW` on `start`.

Top module: `panel_boot_seq`

## Requirements
- R1: Out of reset and until `start`, the following outputs are high: `panel_cs_n`, `panel_wr_n`, `panel_rd_n` and `panel_rst_n`. `done` is low. `panel_rd_n` is never driven low.
- R2: On `start`, `panel_rst_n` goes low for exactly RST_LOW_MS*T cycles (default 20 ms). `panel_cs_n` stays high throughout.
- R3: After `panel_rst_n` rises, exactly RST_WAIT_MS*T cycles (default 50 ms) pass before `panel_cs_n` falls. The first `panel_wr_n` fall comes one cycle after `panel_cs_n` falls.
- R4: `panel_cs_n` stays low without interruption from its fall until the end entry is reached, and `panel_wr_n` is only low while `panel_cs_n` is low.
- R5: Table pairs are used in order: word 2k is the index/marker and word 2k+1 is the value. The default table holds 11 pairs (index,value; hex, W = marker 0xFFFF, waits in decimal ms):
  - (0001,0200), (0003,1028), (0010,0000), (W,200)
  - (0010,14B0), (0011,0107), (W,50)
  - (0012,0019), (W,100)
  - (0007,0173), (W,0)
- R6: A register pair produces four byte strobes, each with `panel_wr_n` low one cycle then high one cycle:
  - index high byte, then index low byte, with `panel_dc` low;
  - value high byte, then value low byte, with `panel_dc` high.
  `panel_d` and `panel_dc` hold their value through the cycle in which `panel_wr_n` rises.
- R7: Successive `panel_wr_n` falls are 2 cycles apart within a pair, including from the index low byte to the value high byte. Between the value low byte of one pair and the index high byte of the next register pair they are 3 cycles apart. Each wait pair of N ms in between adds 1+N*T cycles.
- R8: An end pair (marker, 0) raises `done` 1 cycle after the cycle in which it is fetched. `panel_cs_n` returns high at the same time, and no further strobes follow.
- R9: `done` stays high until the next `start`. A `start` while `done` is high replays the whole sequence from the reset pulse and table pair 0, with identical bytes and timing.
- R10: `start` while a sequence is running, in the reset phases, a wait or a write, has no effect on the bus bytes, their timing or the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| start | input | 1 | Begins the bring-up sequence (ignored while running) |
| done | output | 1 | High once the end entry is reached, until next start |
| panel_rst_n | output | 1 | Active-low hardware reset to the panel |
| panel_cs_n | output | 1 | Active-low chip select |
| panel_dc | output | 1 | Low = register index byte, high = register value byte |
| panel_wr_n | output | 1 | Active-low write strobe, byte latched on rising edge |
| panel_rd_n | output | 1 | Read strobe, held inactive high |
| panel_d | output | 8 | Bus byte |

## Verification
Two functions share a cycle here. In that cycle the byte writer finishes the high phase of the index low byte, and it also accepts the value word of the same pair. The wait timer's expiry likewise falls in the same cycle as the table pointer advance and the next fetch. Every register pair provokes the first case, and every wait pair the second. The bench judges both by the exact spacing of the `panel_wr_n` falls it timestamps, computed from the table and T. A start pulse is also injected during the reset phase and during a 200 ms wait, and the bench checks that nothing moves.

// File: rtl/panel_boot_pkg.sv
package panel_boot_pkg;

    localparam int unsigned WORD_W = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_FETCH,
        ST_IDX,
        ST_DAT,
        ST_WAIT,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/panel_ms_timer.sv
// Millisecond down-counter: a prescaler of TICKS cycles per ms, reloaded on load.
// A load of N (N>0) makes expire pulse in exactly the N*TICKS-th cycle after load.
module panel_ms_timer #(
    parameter int unsigned TICKS = 50000,
    parameter int unsigned MSW   = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [MSW-1:0] ms_in,
    output logic           expire
);
    localparam int unsigned PSW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic           run;
    logic [PSW-1:0] pre;
    logic [MSW-1:0] left;
    logic           wrap;

    assign wrap   = (pre == PSW'(TICKS - 1));
    assign expire = run && wrap && (left == MSW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run  <= 1'b0;
            pre  <= '0;
            left <= '0;
        end else if (load) begin
            run  <= (ms_in != '0);
            pre  <= '0;
            left <= ms_in;
        end else if (run) begin
            if (wrap) begin
                pre  <= '0;
                left <= left - MSW'(1);
                if (left == MSW'(1)) begin
                    run <= 1'b0;
                end
            end else begin
                pre <= pre + PSW'(1);
            end
        end
    end
endmodule

// File: rtl/panel_byte_strobe.sv
// Sends one DW-bit word as DW/BW bytes, most significant first.
// Each byte: one cycle with wr_n low, one with wr_n high, data held across both.
module panel_byte_strobe #(
    parameter int unsigned DW = 16,
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] word,
    output logic          fin,
    output logic          wr_n,
    output logic [BW-1:0] bus
);
    localparam int unsigned NB  = DW / BW;
    localparam int unsigned NPH = 2 * NB;
    localparam int unsigned PW  = (NPH > 1) ? $clog2(NPH) : 1;

    logic          busy;
    logic [PW-1:0] ph;
    logic [DW-1:0] sh;

    assign fin  = busy && (ph == PW'(NPH - 1));
    assign wr_n = !(busy && !ph[0]);
    assign bus  = sh[DW-1 -: BW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ph   <= '0;
            sh   <= '0;
        end else if (go) begin
            busy <= 1'b1;
            ph   <= '0;
            sh   <= word;
        end else if (busy) begin
            if (ph == PW'(NPH - 1)) begin
                busy <= 1'b0;
                ph   <= '0;
            end else begin
                ph <= ph + PW'(1);
            end
            if (ph[0]) begin
                sh <= sh << BW;
            end
        end
    end
endmodule

// File: rtl/panel_boot_rom.sv
// Constant bring-up table, read as a pair of words starting at an even word address.
module panel_boot_rom #(
    parameter logic [15:0] WAIT_MARK = 16'hFFFF,
    parameter int unsigned AW        = 5
) (
    input  logic [AW-1:0] addr,
    output logic [15:0]   w_first,
    output logic [15:0]   w_second
);
    function automatic logic [15:0] word_at(input logic [AW-1:0] a);
        logic [15:0] w;
        unique case (int'(a))
            0:  w = 16'h0001;    1:  w = 16'h0200;
            2:  w = 16'h0003;    3:  w = 16'h1028;
            4:  w = 16'h0010;    5:  w = 16'h0000;
            6:  w = WAIT_MARK;   7:  w = 16'd200;
            8:  w = 16'h0010;    9:  w = 16'h14B0;
            10: w = 16'h0011;    11: w = 16'h0107;
            12: w = WAIT_MARK;   13: w = 16'd50;
            14: w = 16'h0012;    15: w = 16'h0019;
            16: w = WAIT_MARK;   17: w = 16'd100;
            18: w = 16'h0007;    19: w = 16'h0173;
            20: w = WAIT_MARK;   21: w = 16'd0;
            default: w = (a[0]) ? 16'd0 : WAIT_MARK;
        endcase
        return w;
    endfunction

    always_comb begin
        w_first  = word_at(addr);
        w_second = word_at(addr | AW'(1));
    end
endmodule

// File: rtl/panel_boot_seq.sv
module panel_boot_seq
    import panel_boot_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned RST_LOW_MS  = 20,
    parameter int unsigned RST_WAIT_MS = 50,
    parameter logic [15:0] WAIT_MARK   = 16'hFFFF,
    parameter int unsigned BUS_W       = 8,
    parameter int unsigned ROM_AW      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             done,
    output logic             panel_rst_n,
    output logic             panel_cs_n,
    output logic             panel_dc,
    output logic             panel_wr_n,
    output logic             panel_rd_n,
    output logic [BUS_W-1:0] panel_d
);
    localparam int unsigned TICKS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

    seq_state_t          state, state_d;
    logic [ROM_AW-1:0]   ptr, ptr_d;
    logic [WORD_W-1:0]   w_first, w_second;
    logic                tmr_load, tmr_exp;
    logic [WORD_W-1:0]   tmr_ms;
    logic                wr_go, wr_fin;
    logic [WORD_W-1:0]   wr_word;

    panel_boot_rom #(.WAIT_MARK(WAIT_MARK), .AW(ROM_AW)) u_rom (
        .addr    (ptr),
        .w_first (w_first),
        .w_second(w_second)
    );

    panel_ms_timer #(.TICKS(TICKS), .MSW(WORD_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .ms_in (tmr_ms),
        .expire(tmr_exp)
    );

    panel_byte_strobe #(.DW(WORD_W), .BW(BUS_W)) u_strobe (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (wr_go),
        .word (wr_word),
        .fin  (wr_fin),
        .wr_n (panel_wr_n),
        .bus  (panel_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr   <= '0;
        end else begin
            state <= state_d;
            ptr   <= ptr_d;
        end
    end

    // Next state, pointer and sub-block commands
    always_comb begin
        state_d  = state;
        ptr_d    = ptr;
        tmr_load = 1'b0;
        tmr_ms   = '0;
        wr_go    = 1'b0;
        wr_word  = w_first;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d  = ST_RST_LOW;
                    ptr_d    = '0;
                    tmr_load = 1'b1;
                    tmr_ms   = WORD_W'(RST_LOW_MS);
                end
            end
            ST_RST_LOW: begin
                if (tmr_exp) begin
                    state_d  = ST_RST_WAIT;
                    tmr_load = 1'b1;
                    tmr_ms   = WORD_W'(RST_WAIT_MS);
                end
            end
            ST_RST_WAIT: begin
                if (tmr_exp) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (w_first == WAIT_MARK) begin
                    if (w_second == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d  = ST_WAIT;
                        tmr_load = 1'b1;
                        tmr_ms   = w_second;
                    end
                end else begin
                    state_d = ST_IDX;
                    wr_go   = 1'b1;
                    wr_word = w_first;
                end
            end
            ST_IDX: begin
                if (wr_fin) begin
                    state_d = ST_DAT;
                    wr_go   = 1'b1;
                    wr_word = w_second;
                end
            end
            ST_DAT: begin
                if (wr_fin) begin
                    state_d = ST_FETCH;
                    ptr_d   = ptr + ROM_AW'(2);
                end
            end
            ST_WAIT: begin
                if (tmr_exp) begin
                    state_d = ST_FETCH;
                    ptr_d   = ptr + ROM_AW'(2);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        done        = 1'b0;
        panel_rst_n = 1'b1;
        panel_cs_n  = 1'b1;
        panel_dc    = 1'b0;
        panel_rd_n  = 1'b1;
        unique case (state)
            ST_IDLE, ST_RST_WAIT: ;
            ST_RST_LOW:           panel_rst_n = 1'b0;
            ST_FETCH, ST_WAIT,
            ST_IDX:               panel_cs_n  = 1'b0;
            ST_DAT: begin
                panel_cs_n = 1'b0;
                panel_dc   = 1'b1;
            end
            ST_DONE:              done        = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/panel_boot_chk.sv
module panel_boot_chk #(
    parameter int unsigned BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic             panel_rst_n,
    input logic             panel_cs_n,
    input logic             panel_dc,
    input logic             panel_wr_n,
    input logic [BUS_W-1:0] panel_d
);
    AST_RST_WITHOUT_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n |-> panel_cs_n); // R2

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_wr_n |-> !panel_cs_n); // R4

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_wr_n) |-> $stable(panel_d)); // R6

    AST_DC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_wr_n) |-> $stable(panel_dc)); // R6

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (panel_cs_n && panel_wr_n && panel_rst_n)); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R9

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !panel_wr_n) |=> panel_rst_n); // R10
endmodule

bind panel_boot_seq panel_boot_chk #(.BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .panel_rst_n(panel_rst_n),
    .panel_cs_n (panel_cs_n),
    .panel_dc   (panel_dc),
    .panel_wr_n (panel_wr_n),
    .panel_d    (panel_d)
);

// File: tb/test_panel_boot_seq.sv
module test_panel_boot_seq;
    localparam int T     = 8;          // CLK_HZ 8000 -> 8 cycles per ms
    localparam int MARK  = 16'hFFFF;
    localparam int NPAIR = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       done, panel_rst_n, panel_cs_n, panel_dc, panel_wr_n, panel_rd_n;
    logic [7:0] panel_d;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    panel_boot_seq #(.CLK_HZ(8000)) i_panel_boot_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .panel_rst_n(panel_rst_n), .panel_cs_n(panel_cs_n), .panel_dc(panel_dc),
        .panel_wr_n(panel_wr_n), .panel_rd_n(panel_rd_n), .panel_d(panel_d)
    );

    function automatic int tbl(input int i);
        case (i)
            0: return 16'h0001;  1: return 16'h0200;
            2: return 16'h0003;  3: return 16'h1028;
            4: return 16'h0010;  5: return 16'h0000;
            6: return MARK;      7: return 200;
            8: return 16'h0010;  9: return 16'h14B0;
            10: return 16'h0011; 11: return 16'h0107;
            12: return MARK;     13: return 50;
            14: return 16'h0012; 15: return 16'h0019;
            16: return MARK;     17: return 100;
            18: return 16'h0007; 19: return 16'h0173;
            default: return (i % 2 == 1) ? 0 : MARK;
        endcase
    endfunction

    // Bus monitor, sampled on the falling clock edge
    int cyc = 0, nb = 0, t_rf = -1, t_rr = -1, t_cf = -1, t_done = -1;
    int cs_bounce = 0, hold_err = 0, rd_low = 0;
    int bv [64];
    int brs [64];
    int bt [64];
    logic p_rst = 1'b1, p_cs = 1'b1, p_wr = 1'b1, p_done = 1'b0, p_dc = 1'b0;
    logic [7:0] p_d = '0;

    always @(negedge clk) begin
        cyc++;
        if (p_rst && !panel_rst_n) begin
            t_rf = cyc; nb = 0; t_cf = -1; t_done = -1; t_rr = -1;
            cs_bounce = 0; hold_err = 0;
        end
        if (!p_rst && panel_rst_n) t_rr = cyc;
        if (p_cs && !panel_cs_n) t_cf = cyc;
        if (!p_cs && panel_cs_n && !done) cs_bounce++;
        if (p_wr && !panel_wr_n && nb < 64) begin
            bv[nb] = int'(panel_d); brs[nb] = int'(panel_dc); bt[nb] = cyc; nb++;
        end
        if (!p_wr && panel_wr_n && (panel_d != p_d || panel_dc != p_dc)) hold_err++;
        if (!p_done && done) t_done = cyc;
        if (!panel_rd_n) rd_low++;
        p_rst = panel_rst_n; p_cs = panel_cs_n; p_wr = panel_wr_n;
        p_done = done; p_d = panel_d; p_dc = panel_dc;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Compare one captured run against the table and T
    task automatic run_check();
        int f = t_cf;
        int k = 0;
        chk("R2 reset low length", t_rr - t_rf, 20 * T);
        chk("R3 reset-to-select length", t_cf - t_rr, 50 * T);
        for (int p = 0; p < NPAIR; p++) begin
            int w0 = tbl(2 * p);
            int w1 = tbl(2 * p + 1);
            if (w0 == MARK) begin
                if (w1 == 0) begin
                    chk("R8 done timing", t_done, f + 1);
                    break;
                end
                f += 1 + w1 * T;           // R7 wait spacing
            end else begin
                int eb [4];
                eb[0] = w0 >> 8; eb[1] = w0 & 255; eb[2] = w1 >> 8; eb[3] = w1 & 255;
                for (int j = 0; j < 4; j++) begin
                    if (k + j < nb) begin
                        chk("R6 byte value", bv[k + j], eb[j]);
                        chk("R6 dc level", brs[k + j], (j >= 2) ? 1 : 0);
                        chk("R7 strobe time", bt[k + j], f + 1 + 2 * j);
                    end
                end
                k += 4;
                f += 9;
            end
        end
        chk("R5 byte count", nb, k);
        chk("R4 select bounces", cs_bounce, 0);
        chk("R6 held at rising strobe", hold_err, 0);
    endtask

    task automatic wait_done_and_hold();
        int nb_at_done;
        wait (done === 1'b1);
        @(negedge clk);
        nb_at_done = nb;
        repeat (100) @(negedge clk);
        chk("R9 done sticky", int'(done), 1);
        chk("R8 select released", int'(panel_cs_n), 1);
        chk("R8 no strobes after end", nb, nb_at_done);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk("R1 cs_n idle", int'(panel_cs_n), 1);
        chk("R1 wr_n idle", int'(panel_wr_n), 1);
        chk("R1 rd_n idle", int'(panel_rd_n), 1);
        chk("R1 rst_n idle", int'(panel_rst_n), 1);
        chk("R1 done idle", int'(done), 0);
        chk("R1 no strobes before start", nb, 0);

        // Run 1: from idle
        pulse_start();
        wait_done_and_hold();
        run_check();

        // Run 2: restart from done, with starts injected while busy (R10)
        pulse_start();
        repeat (5 * T) @(negedge clk);
        pulse_start();
        repeat (70 * T + 40) @(negedge clk);
        pulse_start();
        wait_done_and_hold();
        run_check();                       // R9 replay and R10 no effect

        // Run 3: start again immediately out of done
        pulse_start();
        wait_done_and_hold();
        run_check();

        chk("R1 rd_n never low", rd_low, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule